// File: doc/BRIEF.md
# Two-Wire Register Slave with Persistent Pointer

This block is a slave on a two-wire serial bus. An external host uses it to read and write a small bank of 8-bit registers. The two bus lines are sampled by a faster system clock. Both lines pass through a two-flop synchronizer and a two-sample agreement filter. Clock edges and the start and stop conditions are then derived from the filtered levels. The slave answers only its own 7-bit device address. It acknowledges by pulling the data line low and never drives the clock line. All drive is open-drain: the single output asks the pad to pull low.

A 16-bit register pointer selects the target register. A write transaction loads the pointer with its high byte first. Every data byte moved in either direction advances the pointer by one. The pointer keeps its value after a stop. A read can therefore continue where the last access ended, and a random read is a pointer write followed by a repeated start and a read. The device address comes from one input pin or from an override register inside the bank.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling data line while the clock is high starts a transaction, and a rising data line while the clock is high ends it. A start that arrives with no stop before it is accepted and begins a new address byte.
- R2: The address byte is sent MSB first. Its bits [7:1] are the device address and bit 0 is the direction (0 write, 1 read). With addr_sel low the slave answers 7'h36 (bytes 0x6C/0x6D); with addr_sel high it answers 7'h37 (bytes 0x6E/0x6F). An accepted byte is acknowledged by holding the data line low during the ninth clock.
- R3: If the address does not match, the slave never pulls the data line low. It ignores every byte until the next start and changes no register.
- R4: In a write, the first two bytes after the address set pointer[15:8] and then pointer[7:0]. Each later byte is stored at the pointer, and every byte is acknowledged.
- R5: The pointer grows by one after each data byte, read or written. This includes a read byte the host does not acknowledge. The register index is pointer[3:0] for the 16-entry bank, so higher pointer bits alias and the index wraps from 15 to 0.
- R6: A read returns bytes MSB first, starting at the current pointer. The pointer survives stop conditions, so a read with no pointer write continues from where the last access ended.
- R7: In a read, a host acknowledge (data low on the ninth clock) fetches the next byte. A host no-acknowledge makes the slave release the data line, and it stays released until the next start or stop.
- R8: Register 15 holds an address override: bit 7 enables it and bits [6:0] give the address. While it is enabled, the pin-selected address is not answered.
- R9: A pulse of one system clock on either bus line is filtered out and does not count as an edge.
- R10: After reset the data line is released, all registers read 0 and the pointer is 0.
- R11: The data-line drive changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel | input | 1 | Chooses device address 7'h37 when high, 7'h36 when low |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The bench writes every register except the override through one auto-increment burst with distinct computed values, then reads them all back through a random read. This separates the pointer sequence, the ordering of the pointer bytes and the shift direction. Further tests use pointers with the high bits set and bursts that wrap at the top index. Each of the three address sources is tried with matching and non-matching addresses, which shows that acknowledges and stores stay gated. Read chains end with a host no-acknowledge and then continue from the current pointer, checking that the pointer persists and the line is released. Single-cycle clock glitches are injected inside written bytes to show the filter absorbs them.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int PTR_W = 16;
    localparam logic [6:0] BASE_ADDR = 7'h36;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK_OUT,
        PH_SEND,
        PH_ACK_IN,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR_HI,
        K_PTR_LO,
        K_DATA
    } kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [6:0] pin_addr(input logic sel);
        return BASE_ADDR | {6'd0, sel};
    endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] filt
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic s1, s2, s3, f;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
                f  <= 1'b1;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                s3 <= s2;
                if (s2 == s3) f <= s2;
            end
        end
        assign filt[g] = f;
    end
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
    parameter int DEPTH   = 16,
    parameter int ALT_IDX = DEPTH - 1,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       alt_reg
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
    assign alt_reg = mem[ALT_IDX];

    // R4: a strobed byte is visible at its index one cycle later
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             sda_f,
    input  logic [6:0]       my_addr,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    phase_e             phase;
    kind_e              kind;
    logic [3:0]         cnt;
    logic [7:0]         sh;
    logic [7:0]         tx;
    logic [PTR_W-1:0]   ptr;
    logic               rw;
    logic               ack_ok;

    assign idx = ptr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= K_ADDR;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            ack_ok  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                phase  <= PH_RECV;
                kind   <= K_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RECV: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            cnt    <= '0;
                            phase  <= PH_ACK_OUT;
                            sda_oe <= 1'b1;
                            unique case (kind)
                                K_ADDR: begin
                                    if (sh[7:1] == my_addr) begin
                                        rw   <= sh[0];
                                        kind <= K_PTR_HI;
                                    end else begin
                                        phase  <= PH_SKIP;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                K_PTR_HI: begin
                                    ptr[PTR_W-1:8] <= sh;
                                    kind <= K_PTR_LO;
                                end
                                K_PTR_LO: begin
                                    ptr[7:0] <= sh;
                                    kind <= K_DATA;
                                end
                                K_DATA: begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr[IDX_W-1:0];
                                    wr_data <= sh;
                                    ptr     <= ptr + 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_ACK_OUT: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[7];
                                phase  <= PH_SEND;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RECV;
                            end
                        end
                    end
                    PH_SEND: begin
                        if (evt.scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                phase  <= PH_ACK_IN;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    PH_ACK_IN: begin
                        if (evt.scl_rise) begin
                            ack_ok <= ~sda_f;
                        end else if (evt.scl_fall) begin
                            if (ack_ok) begin
                                tx     <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[7];
                                phase  <= PH_SEND;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3 / R7: no drive while idle or ignoring the bus
    a_r3_released_when_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_oe);

    // R11: drive only moves on a clock fall or a start/stop
    a_r11_oe_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!evt.scl_fall && !evt.start && !evt.stop) |=> $stable(sda_oe));

    // R5: every stored byte advances the pointer by one
    a_r5_ptr_steps_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ptr == $past(ptr) + 1'b1);

    // R1: bus events are mutually exclusive
    a_r1_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.scl_rise, evt.scl_fall, evt.start, evt.stop}));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ALT_IDX = DEPTH - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    output logic sda_oe
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [1:0] filt;
    lines_t     cur, prev;
    bus_evt_t   evt;

    twi_line_filter #(.LINES(2)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  ({scl_i, sda_i}),
        .filt (filt)
    );

    assign cur = lines_t'(filt);

    always_ff @(posedge clk) begin
        if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
        else     prev <= cur;
    end

    always_comb begin
        evt.scl_rise = cur.scl & ~prev.scl;
        evt.scl_fall = ~cur.scl & prev.scl;
        evt.start    = cur.scl & prev.scl & prev.sda & ~cur.sda;
        evt.stop     = cur.scl & prev.scl & ~prev.sda & cur.sda;
    end

    logic [IDX_W-1:0] idx, wr_idx;
    logic             wr_en;
    logic [7:0]       wr_data, rd_data, alt_reg;
    logic [6:0]       my_addr;

    assign my_addr = alt_reg[7] ? alt_reg[6:0] : pin_addr(addr_sel);

    twi_reg_bank #(.DEPTH(DEPTH), .ALT_IDX(ALT_IDX)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .alt_reg (alt_reg)
    );

    twi_slave_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sda_f   (cur.sda),
        .my_addr (my_addr),
        .rd_data (rd_data),
        .idx     (idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );
endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0, addr_sel = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;
    wire  scl_bus = scl_m | scl_gl;

    int   errors = 0, checks = 0;
    int   r11_viol = 0;
    bit   done = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] wr_buf [16];
    logic [7:0] rd_buf [16];
    bit   acks [20];
    int   ptr_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_reg_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_bus),
        .sda_i    (sda_bus),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe)
    );

    // R11 monitor: drive may change only while the bus clock is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && scl_bus) r11_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                repeat (3) @(negedge clk);
                scl_gl = 1'b1; @(negedge clk); scl_gl = 1'b0;
                repeat (Q - 4) @(negedge clk);
            end else wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = !sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            scl_m = 1'b0; wq();
        end
        sda_m = !mack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 0; wq();
        sda_m = 1'b1;
    endtask

    // address, pointer high, pointer low, then n bytes from wr_buf
    task automatic write_seq(input logic [6:0] dev, input logic [15:0] p, input int n,
                             input bit glitch);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, 1'b0, a); acks[0] = a;
        send_byte(p[15:8], 1'b0, a);     acks[1] = a;
        send_byte(p[7:0], 1'b0, a);      acks[2] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(wr_buf[k], glitch, a); acks[3+k] = a;
        end
        bus_stop();
    endtask

    // current-location read of n bytes; last byte not acknowledged
    task automatic read_cur(input logic [6:0] dev, input int n, output bit addr_ack);
        logic [7:0] b;
        bus_start();
        send_byte({dev, 1'b1}, 1'b0, addr_ack);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b); rd_buf[k] = b;
        end
        chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
        bus_stop();
    endtask

    // pointer write, repeated start, then read n bytes
    task automatic read_at(input logic [6:0] dev, input logic [15:0] p, input int n);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({dev, 1'b0}, 1'b0, a);
        send_byte(p[15:8], 1'b0, a);
        send_byte(p[7:0], 1'b0, a);
        bus_start();
        send_byte({dev, 1'b1}, 1'b0, a);
        chk(a, "R1 repeated start address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b); rd_buf[k] = b;
        end
        bus_stop();
    endtask

    function automatic logic [7:0] val(input int s, input int k);
        return 8'((s * 31 + k * 57 + 3) & 8'hFF);
    endfunction

    initial begin
        bit a;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // reset state
        chk(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
        read_cur(7'h36, 4, a);
        chk(a, "R2 default read address ack", a, 1);
        for (int k = 0; k < 4; k++)
            chk(rd_buf[k] == 8'h00, "R10 registers zero from pointer 0", rd_buf[k], 0);
        ptr_m = 4;

        // sweep: burst write of indices 0..14, random read back
        for (int k = 0; k < 15; k++) wr_buf[k] = val(1, k);
        write_seq(7'h36, 16'h0000, 15, 1'b0);
        for (int k = 0; k < 18; k++) chk(acks[k], "R4 every write byte acked", acks[k], 1);
        for (int k = 0; k < 15; k++) model[k] = val(1, k);
        read_at(7'h36, 16'h0000, 15);
        for (int k = 0; k < 15; k++)
            chk(rd_buf[k] == model[k], "R5 R6 burst read order", rd_buf[k], model[k]);

        // pointer persists across stop; nacked byte still advances
        read_at(7'h36, 16'h0005, 2);
        read_cur(7'h36, 3, a);
        for (int k = 0; k < 3; k++)
            chk(rd_buf[k] == model[7 + k], "R6 current-location read", rd_buf[k], model[7 + k]);
        read_cur(7'h36, 1, a);
        chk(rd_buf[0] == model[10], "R5 nacked byte advanced pointer", rd_buf[0], model[10]);

        // high pointer bits alias onto the low index
        wr_buf[0] = 8'hC3;
        write_seq(7'h36, 16'h1203, 1, 1'b0);
        model[3] = 8'hC3;
        read_at(7'h36, 16'h0003, 1);
        chk(rd_buf[0] == 8'hC3, "R5 pointer high bits alias", rd_buf[0], 8'hC3);

        // wrap from 15 to 0 (index 15 written with override disabled)
        wr_buf[0] = 8'h11; wr_buf[1] = 8'h05; wr_buf[2] = 8'h22;
        write_seq(7'h36, 16'h000E, 3, 1'b0);
        model[14] = 8'h11; model[15] = 8'h05; model[0] = 8'h22;
        read_at(7'h36, 16'h000E, 3);
        chk(rd_buf[0] == 8'h11, "R5 wrap idx14", rd_buf[0], 8'h11);
        chk(rd_buf[1] == 8'h05, "R5 wrap idx15", rd_buf[1], 8'h05);
        chk(rd_buf[2] == 8'h22, "R5 wrap idx0", rd_buf[2], 8'h22);

        // mismatching address is ignored
        wr_buf[0] = 8'hEE;
        write_seq(7'h38, 16'h0002, 1, 1'b0);
        for (int k = 0; k < 4; k++) chk(!acks[k], "R3 no ack on mismatch", acks[k], 0);
        read_at(7'h36, 16'h0002, 1);
        chk(rd_buf[0] == model[2], "R3 register unchanged", rd_buf[0], model[2]);

        // pin-selected alternate address
        addr_sel = 1'b1;
        wr_buf[0] = 8'h77;
        write_seq(7'h36, 16'h0001, 1, 1'b0);
        chk(!acks[0], "R2 base address refused with addr_sel", acks[0], 0);
        write_seq(7'h37, 16'h0001, 1, 1'b0);
        chk(acks[0] && acks[3], "R2 addr_sel address acked", acks[3], 1);
        model[1] = 8'h77;
        read_at(7'h37, 16'h0001, 1);
        chk(rd_buf[0] == 8'h77, "R2 addr_sel write lands", rd_buf[0], 8'h77);
        addr_sel = 1'b0;

        // override register
        wr_buf[0] = 8'hA1;
        write_seq(7'h36, 16'h000F, 1, 1'b0);
        write_seq(7'h36, 16'h0001, 0, 1'b0);
        chk(!acks[0], "R8 pin address overridden", acks[0], 0);
        read_at(7'h21, 16'h000F, 1);
        chk(rd_buf[0] == 8'hA1, "R8 override address answers", rd_buf[0], 8'hA1);
        wr_buf[0] = 8'h00;
        write_seq(7'h21, 16'h000F, 1, 1'b0);
        write_seq(7'h36, 16'h0001, 0, 1'b0);
        chk(acks[0], "R8 pin address back after disable", acks[0], 1);

        // single-cycle clock glitches inside written bytes
        wr_buf[0] = 8'h5A; wr_buf[1] = 8'hA5;
        write_seq(7'h36, 16'h0004, 2, 1'b1);
        read_at(7'h36, 16'h0004, 2);
        chk(rd_buf[0] == 8'h5A, "R9 glitch filtered byte0", rd_buf[0], 8'h5A);
        chk(rd_buf[1] == 8'hA5, "R9 glitch filtered byte1", rd_buf[1], 8'hA5);

        chk(r11_viol == 0, "R11 drive changes with clock low", r11_viol, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule